// File: doc/BRIEF.md
# Table-Driven Carrier PWM Modulator

This block drives one pulse-width-modulated output, intended for a half-bridge power stage. A fixed carrier period of P clocks (200 by default, which at a 40 MHz clock gives a 200 kHz carrier) begins with a pulse. The high time of that pulse comes from a small table of widths. By default the table has 20 entries, so a full pass repeats at 10 kHz. One table entry is used per carrier period, and the entry index advances every period. The sequence of widths therefore shapes a slower waveform on top of the carrier.

A host fills and rewrites the table through a write port with address, data and enable. The modulator reads the table on its own side at the same time. The host changes the amplitude of the slow waveform only by rewriting entries, so the width resolution sets the size of each amplitude step. The width of an entry is taken at the first cycle of its period and held for the rest of that period. A rewrite in the middle of a period therefore never cuts the running pulse short. Two strobes are provided for observation: one marks each period start, and the other marks the period that uses entry 0.

Top module: `pwm_table_mod`

## Requirements
- R1: The reset `rst` is synchronous and active high. While it is high, `pwm_out`, `period_start` and `table_wrap` are 0. In the first cycle after it is released, the period counter and the table index are both 0, so `period_start` and `table_wrap` are both 1.
- R2: A carrier period lasts exactly P cycles (default 200). `period_start` is 1 only in the first cycle of each period.
- R3: In a period that uses table entry k with width w, `pwm_out` is 1 for cycle positions 0 to w-1 of that period and 0 for the rest. Position 0 is the `period_start` cycle.
- R4: A width of 0 keeps `pwm_out` at 0 for the whole period.
- R5: A width of P or more keeps `pwm_out` at 1 for all P cycles. If the next width is also P or more, the output stays high across the period boundary without a low cycle.
- R6: The table index starts at 0 and advances by one per period. After entry L-1 (default 19) it returns to 0. `table_wrap` is 1 exactly in the start cycle of a period that uses entry 0.
- R7: The width of a period is captured in its start cycle. A write to the entry in use takes effect only from that entry's next use. This holds for a write sampled at the end of the start cycle and for any later write in the same period.
- R8: A write to any address of L or above (20 to 31 by default) changes no table entry.
- R9: Table writes are accepted in every cycle, including while `rst` is high. The table contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | AW (5) | Table entry to write |
| wr_data | input | WW (8) | Pulse width in clock cycles |
| pwm_out | output | 1 | Modulated output |
| period_start | output | 1 | High in the first cycle of each carrier period |
| table_wrap | output | 1 | High in the start cycle of the period that uses entry 0 |

## Verification
All outputs are combinational functions of registers that update on the same edge, and of `rst`. They therefore settle one edge after the inputs that caused them. A table write driven in a cycle is stored at the closing edge of that cycle. It is visible to the width read from the following cycle onward. The width of a period is frozen at the edge that ends its start cycle. The bench drives inputs and compares all three outputs at the falling edge of every cycle. It keeps a model of counter, index, held width and table that steps on each rising edge. Every expected value therefore refers to the cycle whose registers are already settled.

// File: rtl/pwm_table_mod.sv
module pwm_table_mod #(
  parameter int P  = 200,
  parameter int L  = 20,
  parameter int WW = 8,
  localparam int CW = $clog2(P),
  localparam int AW = $clog2(L)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [WW-1:0] wr_data,
  output logic          pwm_out,
  output logic          period_start,
  output logic          table_wrap
);

  logic [WW-1:0] tbl [0:L-1];
  logic [CW-1:0] cnt;
  logic [AW-1:0] idx;
  logic [WW-1:0] hold;
  logic [WW-1:0] cur_w;

  always_ff @(posedge clk)
    if (wr_en && (32'(wr_addr) < L)) tbl[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      idx  <= '0;
      hold <= '0;
    end else begin
      if (cnt == '0) hold <= tbl[idx];
      if (cnt == CW'(P-1)) begin
        cnt <= '0;
        idx <= (idx == AW'(L-1)) ? '0 : idx + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign cur_w        = (cnt == '0) ? tbl[idx] : hold;
  assign pwm_out      = !rst && (32'(cnt) < 32'(cur_w));
  assign period_start = !rst && (cnt == '0);
  assign table_wrap   = period_start && (idx == '0);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (period_start && table_wrap));

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < P);

  p_start_gap_r2: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);

  p_zero_low_r4: assert property (@(posedge clk) disable iff (rst)
    (!period_start && hold == '0) |-> !pwm_out);

  p_full_high_r5: assert property (@(posedge clk) disable iff (rst)
    (!period_start && 32'(hold) >= P) |-> pwm_out);

  p_idx_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(P-1)) |=> (table_wrap == ($past(idx) == AW'(L-1))));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (32'(cnt) > 1) |-> $stable(hold));

endmodule

// File: tb/pwm_table_mod_bench.sv
module pwm_table_mod_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out, period_start, table_wrap;

  int total = 0, bad = 0;
  int mmem [20];
  int mcnt = 0, midx = 0, mhold = 0;
  bit mrst = 1'b1;

  always #2 clk = ~clk;

  pwm_table_mod u_pwm_table_mod (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .period_start(period_start), .table_wrap(table_wrap)
  );

  function automatic int exp_high(int pos, int w);
    return (pos < w) ? 1 : 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit r, bit we, int a, int d, string ctx);
    int w;
    string t;
    @(negedge clk);
    if (mrst) begin
      check({"R1", ctx}, int'(pwm_out), 0);
      check({"R1", ctx}, int'(period_start), 0);
      check({"R1", ctx}, int'(table_wrap), 0);
    end else begin
      w = (mcnt == 0) ? mmem[midx] : mhold;
      t = (w == 0) ? "R4" : ((w >= 200) ? "R5" : "R3");
      check({t, ctx}, int'(pwm_out), exp_high(mcnt, w));
      check({"R2", ctx}, int'(period_start), (mcnt == 0) ? 1 : 0);
      check({"R6", ctx}, int'(table_wrap), (mcnt == 0 && midx == 0) ? 1 : 0);
    end
    rst = r; wr_en = we; wr_addr = a[4:0]; wr_data = d[7:0];
    @(posedge clk);
    if (r) begin
      mcnt = 0; midx = 0; mhold = 0;
    end else begin
      if (mcnt == 0) mhold = mmem[midx];
      if (mcnt == 199) begin
        mcnt = 0;
        midx = (midx == 19) ? 0 : midx + 1;
      end else mcnt++;
    end
    if (we && a < 20) mmem[a] = d;
    mrst = r;
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL R2 watchdog actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R9: the table is loaded while reset is held
    for (int i = 0; i < 20; i++) begin
      int v;
      case (i)
        0: v = 0;   1: v = 200; 2: v = 255; 3: v = 1;
        4: v = 199; 5: v = 120; 6: v = 40;
        default: v = int'($urandom_range(0, 255));
      endcase
      step(1'b1, 1'b1, i, v, " R9");
    end
    // R1: reset release, first period, then random legal rewrites
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 63) == 0)
        step(1'b0, 1'b1, int'($urandom_range(7, 19)), int'($urandom_range(0, 255)), " R1");
      else
        step(1'b0, 1'b0, 0, 0, " R1");
    end
    // R7: rewrite the entry in use mid-period and in its start cycle
    for (int c = 0; c < 4000; c++) begin
      if (midx == 5 && mcnt == 50)      step(1'b0, 1'b1, 5, 3, " R7");
      else if (midx == 6 && mcnt == 0) step(1'b0, 1'b1, 6, 190, " R7");
      else                             step(1'b0, 1'b0, 0, 0, " R7");
    end
    // R8: writes to addresses 20..31 must leave the table untouched
    for (int c = 0; c < 4400; c++) begin
      if (c % 7 == 0) step(1'b0, 1'b1, 20 + int'($urandom_range(0, 11)), 255, " R8");
      else            step(1'b0, 1'b0, 0, 0, " R8");
    end
    // R1: reset in the middle of a pass
    for (int c = 0; c < 3; c++) step(1'b1, 1'b0, 0, 0, " R1");
    // mixed random traffic, any address
    for (int c = 0; c < 8000; c++) begin
      if ($urandom_range(0, 31) == 0)
        step(1'b0, 1'b1, int'($urandom_range(0, 31)), int'($urandom_range(0, 255)), "");
      else
        step(1'b0, 1'b0, 0, 0, "");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule